// File: doc/BRIEF.md
# Clock Generator Mode Sequencer

This block is the control state machine of a four-bank clock synthesizer. It watches the two serial-bus lines, the combined serial-clock/power-down line, a mixed-mode control pin, the PLL lock indication and the tri-level frequency-select codes. From these it chooses one of four operating modes: waiting for lock, pin-strap, serial-programmed or power-down. It then drives, for every output bank, an active flag, a frequency code, an output type and the level that the B pin holds while the bank is static.

After reset every bank takes its frequency and type from its select code. Every bank is held at the static differential level (A low, B high) until the PLL reports lock. At lock the sequencer picks a mode. If both bus lines are low it enters pin-strap mode, in which the banks follow their select codes. If not, it enters serial mode, in which the mixed-mode pin, read once, chooses which banks run from their latched pin settings. A serial engine outside this block can later override any bank with its own configuration.

Top module: `clkgen_mode_seq`

## Requirements
- R1: During and straight after reset, every bank is inactive with its B level high, power-down and serial-ready are low, and each bank's frequency and type show the decode of its present select code. Codes are 2'b00 low, 2'b01 mid, 2'b10 high, and 2'b11 is read as mid. Type is 1 for differential and 0 for single-ended. Frequency codes are 0=25, 1=33.33, 2=50, 3=66.66, 4=100, 5=125, 6=133.33, 7=156.25 and 8=161.1328 MHz. Bank n's frequency sits in freq_o[4n+3:4n].
- R2: No bank is active before lock_i has been seen high since the last reset or power-down.
- R3: At lock, with SDA and SCL/PD both low, pin-strap mode starts and all four banks become active whatever the mixed-mode pin is.
- R4: In pin-strap mode banks 1 to 3 are differential. Low selects 156.25 MHz on all three. Mid selects 25, 100 and 125 MHz on banks 1, 2 and 3. High selects 50, 125 and 50 MHz on banks 1, 2 and 3.
- R5: Bank 4 decodes the pair (FS4A, FS4B). With FS4A low it is single-ended: FS4B low, mid and high give 33.33, 66.66 and 133.33 MHz. With FS4A mid it is differential: 133.33, 156.25 and 125 MHz. With FS4A high it is differential: 25, 100 and 161.1328 MHz.
- R6: Once SDA is seen high, the block stays in serial mode until reset, even if SDA then falls and SCL/PD rises. Leaving pin-strap mode this way sets every bank whose configuration comes from its pins to static.
- R7: In pin-strap eligibility, SDA low with SCL/PD high raises pd_o and makes every bank static. SCL/PD low then restarts the sequence: the banks reload from the select pins and stay static until lock.
- R8: In serial mode with the mixed-mode pin low, every pin-configured bank stays static and addr_o carries {FS4A, FS4B} as latched when serial mode was entered. Otherwise addr_o is 0.
- R9: In serial mode with the mixed-mode pin high and FS4A low, only bank 4 is active, using its pin decode.
- R10: In serial mode with the mixed-mode pin high and FS4A mid or high, banks 1 to 3 are active and bank 4 is static.
- R11: In serial mode, changes on the select pins do not change any pin-configured bank's frequency or type.
- R12: In pin-strap mode, a change of a bank's select code makes that bank inactive for exactly HOLD_CYC cycles. The bank then reactivates with the new configuration, and the other banks are unaffected.
- R13: In serial mode a bank marked programmed uses the programmed frequency, type and enable. If it is disabled, it is inactive with B low when single-ended and B high when differential.
- R14: In serial mode a bank not marked programmed keeps the configuration decoded from its pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sda_i | input | 1 | Serial data line level (asynchronous) |
| scl_pd_i | input | 1 | Serial clock / power-down line level (asynchronous) |
| mix_i | input | 1 | Mixed-mode control pin (asynchronous) |
| lock_i | input | 1 | PLL lock indication |
| sel_i | input | 10 | Tri-level codes: [1:0] bank 1, [3:2] bank 2, [5:4] bank 3, [7:6] FS4A, [9:8] FS4B |
| prog_vld_i | input | 4 | Bank configured by serial engine |
| prog_en_i | input | 4 | Serial enable per bank |
| prog_type_i | input | 4 | Serial output type per bank (1 differential) |
| prog_freq_i | input | 16 | Serial frequency code per bank |
| active_o | output | 4 | Bank toggling (1) or static (0) |
| freq_o | output | 16 | Selected frequency code per bank |
| type_o | output | 4 | Selected output type per bank |
| stat_b_o | output | 4 | B pin level while static; A is always low |
| pd_o | output | 1 | Power-down request |
| ser_rdy_o | output | 1 | Serial mode running |
| addr_o | output | 4 | Bus address code {FS4A, FS4B} |

## Verification
The assertions check on every cycle several rules. No bank runs before lock since the last reset or power-down. Power-down forces all banks static and excludes serial mode. Serial mode, once entered, persists. A serially disabled bank is never active. Pin-configured banks never all run at once in serial mode, and their frequencies hold still there. Only the bench scenarios can show the decode tables themselves, the exact length of the hold after a code change, the reload of the pins on restart, the latched address, and the B level of a disabled single-ended or differential bank.

// File: rtl/clkgen_seq_pkg.sv
package clkgen_seq_pkg;

  localparam int FREQ_W = 4;

  typedef enum logic [FREQ_W-1:0] {
    FQ_25M  = 4'd0,
    FQ_33M  = 4'd1,
    FQ_50M  = 4'd2,
    FQ_66M  = 4'd3,
    FQ_100M = 4'd4,
    FQ_125M = 4'd5,
    FQ_133M = 4'd6,
    FQ_156M = 4'd7,
    FQ_161M = 4'd8
  } freq_e;

  typedef enum logic [1:0] {
    MD_WAIT = 2'd0,
    MD_PIN  = 2'd1,
    MD_SER  = 2'd2,
    MD_PD   = 2'd3
  } mode_e;

  localparam logic [1:0] TRI_LO  = 2'b00;
  localparam logic [1:0] TRI_MID = 2'b01;
  localparam logic [1:0] TRI_HI  = 2'b10;

  typedef struct packed {
    logic              diff;
    logic [FREQ_W-1:0] freq;
  } bank_cfg_t;

  function automatic logic [1:0] tri_norm(input logic [1:0] c);
    return (c == 2'b11) ? TRI_MID : c;
  endfunction

  // code[1:0]: own select (or FS4A), code[3:2]: FS4B for the last bank
  function automatic bank_cfg_t pin_decode(input int bank, input logic [3:0] code);
    bank_cfg_t  r;
    logic [1:0] a;
    logic [1:0] b;
    a = tri_norm(code[1:0]);
    b = tri_norm(code[3:2]);
    r.diff = 1'b1;
    r.freq = FQ_156M;
    if (bank < 3) begin
      case (a)
        TRI_MID: r.freq = (bank == 0) ? FQ_25M : (bank == 1) ? FQ_100M : FQ_125M;
        TRI_HI:  r.freq = (bank == 1) ? FQ_125M : FQ_50M;
        default: r.freq = FQ_156M;
      endcase
    end else begin
      case (a)
        TRI_LO: begin
          r.diff = 1'b0;
          r.freq = (b == TRI_LO) ? FQ_33M : (b == TRI_MID) ? FQ_66M : FQ_133M;
        end
        TRI_MID: r.freq = (b == TRI_LO) ? FQ_133M : (b == TRI_MID) ? FQ_156M : FQ_125M;
        default: r.freq = (b == TRI_LO) ? FQ_25M : (b == TRI_MID) ? FQ_100M : FQ_161M;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/clkgen_sync.sv
module clkgen_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/clkgen_mode_fsm.sv
module clkgen_mode_fsm
  import clkgen_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sda_s_i,
  input  logic                 scl_s_i,
  input  logic                 mix_s_i,
  input  logic                 lock_i,
  input  logic [1:0]           fs4a_i,
  input  logic [1:0]           fs4b_i,
  output mode_e                mode_o,
  output logic [NUM_BANKS-1:0] ser_en_o,
  output logic [3:0]           addr_o
);

  localparam logic [NUM_BANKS-1:0] LAST_ONLY = {1'b1, {(NUM_BANKS-1){1'b0}}};
  localparam logic [NUM_BANKS-1:0] REST_ONLY = ~LAST_ONLY;

  mode_e                mode_q, mode_d;
  logic                 strap_q;
  logic                 mix_lo_q;
  logic [3:0]           addr_q;
  logic [NUM_BANKS-1:0] ser_en_q;
  logic                 pd_req;
  logic                 enter_ser;

  // pin-strap eligibility is lost for good on any SDA high
  assign pd_req = strap_q && !sda_s_i && scl_s_i;

  always_comb begin
    mode_d    = mode_q;
    enter_ser = 1'b0;
    unique case (mode_q)
      MD_WAIT: begin
        if (pd_req) mode_d = MD_PD;
        else if (lock_i) begin
          if (strap_q && !sda_s_i) mode_d = MD_PIN;
          else begin
            mode_d    = MD_SER;
            enter_ser = 1'b1;
          end
        end
      end
      MD_PIN: begin
        if (pd_req) mode_d = MD_PD;
        else if (sda_s_i) begin
          mode_d    = MD_SER;
          enter_ser = 1'b1;
        end
      end
      MD_PD:   if (!scl_s_i || sda_s_i) mode_d = MD_WAIT;
      default: mode_d = MD_SER;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MD_WAIT;
      strap_q  <= 1'b1;
      mix_lo_q <= 1'b0;
      addr_q   <= '0;
      ser_en_q <= '0;
    end else begin
      mode_q <= mode_d;
      if (sda_s_i) strap_q <= 1'b0;
      if (enter_ser) begin
        mix_lo_q <= !mix_s_i;
        addr_q   <= {fs4a_i, fs4b_i};
        if (!mix_s_i)                    ser_en_q <= '0;
        else if (tri_norm(fs4a_i) == TRI_LO) ser_en_q <= LAST_ONLY;
        else                             ser_en_q <= REST_ONLY;
      end
    end
  end

  assign mode_o   = mode_q;
  assign ser_en_o = ser_en_q;
  assign addr_o   = (mode_q == MD_SER && mix_lo_q) ? addr_q : 4'd0;

endmodule

// File: rtl/clkgen_bank.sv
module clkgen_bank
  import clkgen_seq_pkg::*;
#(
  parameter int BANK_IDX = 0,
  parameter int HOLD_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        code_i,
  input  mode_e             mode_i,
  input  logic              ser_en_i,
  input  logic              prog_vld_i,
  input  logic              prog_en_i,
  input  logic              prog_type_i,
  input  logic [FREQ_W-1:0] prog_freq_i,
  output logic              active_o,
  output logic [FREQ_W-1:0] freq_o,
  output logic              type_o,
  output logic              stat_b_o
);

  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYC);

  logic [3:0]       code_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tracking;
  bank_cfg_t        pin_cfg;

  assign tracking = (mode_i == MD_WAIT) || (mode_i == MD_PD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      cnt_q  <= '0;
    end else if (tracking) begin
      code_q <= code_i;
      cnt_q  <= '0;
    end else if (mode_i == MD_PIN) begin
      if (code_i != code_q) begin
        code_q <= code_i;
        cnt_q  <= CNT_LOAD;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign pin_cfg = pin_decode(BANK_IDX, tracking ? code_i : code_q);

  always_comb begin
    freq_o   = pin_cfg.freq;
    type_o   = pin_cfg.diff;
    active_o = 1'b0;
    stat_b_o = 1'b1;
    unique case (mode_i)
      MD_PIN: active_o = (cnt_q == '0);
      MD_SER: begin
        if (prog_vld_i) begin
          freq_o   = prog_freq_i;
          type_o   = prog_type_i;
          active_o = prog_en_i;
          stat_b_o = prog_type_i;
        end else begin
          active_o = ser_en_i;
        end
      end
      default: active_o = 1'b0;
    endcase
    if (active_o) stat_b_o = 1'b0;
  end

endmodule

// File: rtl/clkgen_mode_seq.sv
module clkgen_mode_seq
  import clkgen_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int HOLD_CYC  = 16,
  parameter int SYNC_STG  = 2,
  localparam int SEL_W    = 2 * (NUM_BANKS + 1),
  localparam int FRQ_W    = NUM_BANKS * FREQ_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sda_i,
  input  logic                 scl_pd_i,
  input  logic                 mix_i,
  input  logic                 lock_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic [NUM_BANKS-1:0] prog_vld_i,
  input  logic [NUM_BANKS-1:0] prog_en_i,
  input  logic [NUM_BANKS-1:0] prog_type_i,
  input  logic [FRQ_W-1:0]     prog_freq_i,
  output logic [NUM_BANKS-1:0] active_o,
  output logic [FRQ_W-1:0]     freq_o,
  output logic [NUM_BANKS-1:0] type_o,
  output logic [NUM_BANKS-1:0] stat_b_o,
  output logic                 pd_o,
  output logic                 ser_rdy_o,
  output logic [3:0]           addr_o
);

  localparam int LAST = NUM_BANKS - 1;

  logic [2:0]           pins_s;
  mode_e                mode;
  logic [NUM_BANKS-1:0] ser_en;
  logic [1:0]           fs4a;
  logic [1:0]           fs4b;

  assign fs4a = sel_i[2*LAST +: 2];
  assign fs4b = sel_i[2*LAST+2 +: 2];

  clkgen_sync #(.W(3), .STAGES(SYNC_STG)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({mix_i, scl_pd_i, sda_i}),
    .q_o    (pins_s)
  );

  clkgen_mode_fsm #(.NUM_BANKS(NUM_BANKS)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sda_s_i  (pins_s[0]),
    .scl_s_i  (pins_s[1]),
    .mix_s_i  (pins_s[2]),
    .lock_i   (lock_i),
    .fs4a_i   (fs4a),
    .fs4b_i   (fs4b),
    .mode_o   (mode),
    .ser_en_o (ser_en),
    .addr_o   (addr_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [3:0] code;
    if (b == LAST) begin : g_pair
      assign code = {fs4b, fs4a};
    end else begin : g_single
      assign code = {2'b00, sel_i[2*b +: 2]};
    end

    clkgen_bank #(.BANK_IDX(b), .HOLD_CYC(HOLD_CYC)) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .code_i      (code),
      .mode_i      (mode),
      .ser_en_i    (ser_en[b]),
      .prog_vld_i  (prog_vld_i[b]),
      .prog_en_i   (prog_en_i[b]),
      .prog_type_i (prog_type_i[b]),
      .prog_freq_i (prog_freq_i[b*FREQ_W +: FREQ_W]),
      .active_o    (active_o[b]),
      .freq_o      (freq_o[b*FREQ_W +: FREQ_W]),
      .type_o      (type_o[b]),
      .stat_b_o    (stat_b_o[b])
    );
  end

  assign pd_o      = (mode == MD_PD);
  assign ser_rdy_o = (mode == MD_SER);

endmodule

// File: rtl/clkgen_mode_seq_chk.sv
module clkgen_mode_seq_chk #(
  parameter int NUM_BANKS = 4,
  parameter int FRQ_W     = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 lock_i,
  input logic [NUM_BANKS-1:0] prog_vld_i,
  input logic [NUM_BANKS-1:0] prog_en_i,
  input logic [NUM_BANKS-1:0] active_o,
  input logic [FRQ_W-1:0]     freq_o,
  input logic                 pd_o,
  input logic                 ser_rdy_o
);

  logic seen_lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seen_lock_q <= 1'b0;
    else if (pd_o)   seen_lock_q <= 1'b0;
    else if (lock_i) seen_lock_q <= 1'b1;
  end

  // R2
  no_early_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_lock_q |-> active_o == '0);

  // R7
  pd_static_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_o |-> (active_o == '0 && !ser_rdy_o));

  // R6
  ser_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_rdy_o |=> ser_rdy_o);

  // R13
  ser_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_rdy_o |-> (active_o & prog_vld_i & ~prog_en_i) == '0);

  // R10
  ser_pin_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_rdy_o && prog_vld_i == '0) |-> active_o != '1);

  // R11
  ser_freq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_rdy_o && $past(ser_rdy_o) && prog_vld_i == '0 && $past(prog_vld_i) == '0)
      |-> $stable(freq_o));

endmodule

bind clkgen_mode_seq clkgen_mode_seq_chk #(.NUM_BANKS(NUM_BANKS), .FRQ_W(FRQ_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lock_i     (lock_i),
  .prog_vld_i (prog_vld_i),
  .prog_en_i  (prog_en_i),
  .active_o   (active_o),
  .freq_o     (freq_o),
  .pd_o       (pd_o),
  .ser_rdy_o  (ser_rdy_o)
);

// File: tb/sim_clkgen_mode_seq.sv
module sim_clkgen_mode_seq;

  localparam int HOLD = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sda = 1'b0, scl = 1'b0, mix = 1'b0, lock = 1'b0;
  logic [9:0]  sel = 10'b01_01_01_01_01;
  logic [3:0]  pvld = '0, pen = '0, ptype = '0;
  logic [15:0] pfreq = '0;
  logic [3:0]  active, typ, statb, addr;
  logic [15:0] freq;
  logic        pd, rdy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clkgen_mode_seq #(.HOLD_CYC(HOLD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sda_i(sda), .scl_pd_i(scl), .mix_i(mix),
    .lock_i(lock), .sel_i(sel), .prog_vld_i(pvld), .prog_en_i(pen),
    .prog_type_i(ptype), .prog_freq_i(pfreq), .active_o(active),
    .freq_o(freq), .type_o(typ), .stat_b_o(statb), .pd_o(pd),
    .ser_rdy_o(rdy), .addr_o(addr)
  );

  // {sel(FS4B,FS4A,FS3,FS2,FS1), freq{b4,b3,b2,b1}, type{b4..b1}}
  localparam logic [29:0] VEC [9] = '{
    {10'b00_00_00_00_00, 16'h1777, 4'b0111},
    {10'b01_00_01_01_01, 16'h3540, 4'b0111},
    {10'b10_00_10_10_10, 16'h6252, 4'b0111},
    {10'b00_01_10_01_00, 16'h6247, 4'b1111},
    {10'b01_01_00_10_01, 16'h7750, 4'b1111},
    {10'b10_01_01_00_10, 16'h5572, 4'b1111},
    {10'b00_10_00_00_00, 16'h0777, 4'b1111},
    {10'b01_10_01_01_01, 16'h4540, 4'b1111},
    {10'b10_10_10_10_10, 16'h8252, 4'b1111}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic restart(input logic s_sda, input logic s_mix, input logic [9:0] s_sel);
    rst_n = 1'b0;
    lock = 1'b0; scl = 1'b0;
    sda = s_sda; mix = s_mix; sel = s_sel;
    pvld = '0; pen = '0; ptype = '0; pfreq = '0;
    tick(3);
    rst_n = 1'b1;
    tick(5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mix = 1'b1;
    tick(2);
    // R1 reset state and preload
    chk("R1 active", active, 4'h0);
    chk("R1 statb", statb, 4'hf);
    chk("R1 pd/rdy", {pd, rdy}, 2'b00);
    chk("R1 freq", freq, 16'h7540);
    chk("R1 type", typ, 4'hf);
    rst_n = 1'b1;
    tick(6);
    chk("R2 no lock", active, 4'h0);
    lock = 1'b1;
    tick(3);
    chk("R3 pin strap all", active, 4'hf);
    chk("R3 rdy", {pd, rdy}, 2'b00);

    for (int i = 0; i < 9; i++) begin
      sel = VEC[i][29:20];
      tick(HOLD + 6);
      chk("R4 banks1-3 freq", freq[11:0], VEC[i][15:4]);
      chk("R5 bank4 freq", freq[15:12], VEC[i][19:16]);
      chk("R5 type", typ, VEC[i][3:0]);
      chk("R4 active", active, 4'hf);
    end

    // R12 hold after code change on bank 2 only
    begin
      int low2 = 0;
      int low1 = 0;
      sel = 10'b10_10_10_00_10;
      for (int k = 0; k < 100; k++) begin
        @(negedge clk);
        if (!active[0]) low1++;
        if (active[1]) break;
        low2++;
      end
      chk("R12 hold length", low2, HOLD);
      chk("R12 other bank", low1, 0);
      chk("R12 new freq", freq[7:4], 4'd7);
    end

    // R7 power-down and restart
    scl = 1'b1;
    tick(4);
    chk("R7 pd", {pd, active}, 5'b1_0000);
    lock = 1'b0;
    sel = 10'b01_01_01_01_01;
    tick(2);
    scl = 1'b0;
    tick(4);
    chk("R7 restart static", {pd, rdy, active}, 6'b00_0000);
    chk("R7 reload", freq, 16'h7540);
    lock = 1'b1;
    tick(3);
    chk("R7 relock", active, 4'hf);

    // R6 exit pin strap
    mix = 1'b0;
    sda = 1'b1;
    tick(4);
    chk("R6 serial", {rdy, active}, 5'b1_0000);
    sda = 1'b0; scl = 1'b1;
    tick(4);
    chk("R6 sticky", {pd, rdy}, 2'b01);
    scl = 1'b0;

    // serial, mixed low
    restart(1'b1, 1'b0, 10'b00_10_01_01_01);
    lock = 1'b1;
    tick(3);
    chk("R8 static", {rdy, active}, 5'b1_0000);
    chk("R8 addr", addr, 4'b1000);
    pvld = 4'b0100; pen = 4'b0100; ptype = 4'b0100; pfreq = 16'h0800;
    tick(1);
    chk("R13 prog active", active, 4'b0100);
    chk("R13 prog freq", freq[11:8], 4'd8);
    chk("R14 bank4 pin", {typ[3], freq[15:12]}, 5'b1_0000);
    pvld = 4'b0101; pen = 4'b0100; ptype = 4'b0100;
    tick(1);
    chk("R13 se disabled", {active[0], statb[0]}, 2'b00);
    ptype = 4'b0101;
    tick(1);
    chk("R13 diff disabled", {active[0], statb[0]}, 2'b01);

    // serial, mixed high, FS4A low
    restart(1'b1, 1'b1, 10'b10_00_01_01_01);
    lock = 1'b1;
    tick(3);
    chk("R9 bank4 only", active, 4'b1000);
    chk("R9 bank4 cfg", {typ[3], freq[15:12]}, 5'b0_0110);
    chk("R9 addr", addr, 4'b0000);
    sel = 10'b00_00_10_10_10;
    tick(4);
    chk("R11 pins ignored", freq, 16'h6540);

    // serial, mixed high, FS4A mid
    restart(1'b1, 1'b1, 10'b01_01_01_01_01);
    lock = 1'b1;
    tick(3);
    chk("R10 banks1-3", active, 4'b0111);
    chk("R10 statb", statb, 4'b1000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule